// File: doc/BRIEF.md
# Reset-Held Boot Image Copier

At power-up the processor has nothing sensible to run. This block keeps the processor in reset and becomes the only master of the RAM write path. It reads a fixed boot image out of a small on-chip nonvolatile table and writes it into RAM one byte at a time. The first byte goes to address zero, and each following byte goes to the next higher address. After the last byte has been written, the block lets go of the processor reset, so the first fetch finds a complete program at address zero.

A boot-source ready input decides when the copy may begin. If that input never goes high, the processor is held in reset indefinitely. Each byte costs one table read cycle followed by a write cycle. The write port is valid/ready. The block raises `wr_valid` with a stable address and data, and the RAM side accepts the beat in any cycle where `wr_ready` is high. If `wr_ready` stays low, the block holds the same beat for as many cycles as needed and does not move on to the next byte. The done flag rises in the same cycle that the processor is released. Both conditions persist until the next system reset.

Top module: `boot_copier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cpu_hold` is 1, `done` is 0 and `wr_valid` is 0.
- R2: While idle with `src_ready` low, no write beat is offered (`wr_valid` stays 0) and `cpu_hold` stays 1, for any number of cycles.
- R3: `src_ready` sampled high while idle starts the copy. Once started, later values of `src_ready` are ignored, and the copy still runs to completion.
- R4: Accepted write addresses run 0, 1, 2, ... IMG_LEN-1 with no gap or repeat. Exactly IMG_LEN beats are accepted per copy.
- R5: The byte written at address i equals the low DATA_W bits of ((i*37 + 5) XOR (i >> 3)).
- R6: Each byte takes one table read cycle before its write beat. After an accepted beat, `wr_valid` is 0 in the following cycle.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, the next cycle keeps `wr_valid` at 1 with `wr_addr` and `wr_data` unchanged.
- R8: `cpu_hold` falls and `done` rises in the same cycle. This happens only in the cycle after the beat for address IMG_LEN-1 is accepted.
- R9: Once `done` is 1, it stays 1 and `cpu_hold` stays 0, with no further write beats, until `rst_n` goes low.
- R10: Asserting `rst_n` low in the middle of a copy reasserts `cpu_hold` at once. The next copy starts again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| src_ready | input | 1 | Boot source ready; gates the start of the copy |
| wr_ready | input | 1 | RAM accepts the offered write beat |
| wr_valid | output | 1 | Write beat offered (write strobe) |
| wr_addr | output | ADDR_W | RAM write address |
| wr_data | output | DATA_W | RAM write data |
| cpu_hold | output | 1 | Processor reset, active high |
| done | output | 1 | Copy finished, processor released |

## Verification
The assertions check the cycle-level rules on every clock. These are: the stall-hold rule on the write port, the idle cycle that follows every accepted beat, the release happening only right after the final address is accepted, the stickiness of the done state, and the absence of beats after done. Only the bench's scenarios can show the rest. That includes the full address sequence and image contents across a whole copy, the indefinite idle while the source is not ready, the ignored ready input after the start, and a restart from address zero after a reset in mid-copy, all under several back-pressure patterns.

// File: rtl/boot_copier_pkg.sv
`timescale 1ns/1ps
package boot_copier_pkg;

  typedef enum logic [1:0] {
    CP_IDLE  = 2'd0,
    CP_READ  = 2'd1,
    CP_WRITE = 2'd2,
    CP_DONE  = 2'd3
  } cp_state_t;

  // Boot image contents: one word per index, truncated by the user.
  function automatic logic [31:0] image_word(input int unsigned idx);
    logic [31:0] a;
    a = idx * 32'd37 + 32'd5;
    return a ^ (idx >> 3);
  endfunction

endpackage

// File: rtl/boot_rom.sv
`timescale 1ns/1ps
module boot_rom #(
  parameter int IMG_LEN = 128,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  import boot_copier_pkg::*;

  logic [31:0] word;

  always_comb word = image_word(32'(rd_idx));

  // Synchronous read: data appears the cycle after rd_en.
  generate
    if (DATA_W <= 32) begin : g_narrow
      always_ff @(posedge clk) begin
        if (rd_en) rd_data <= word[DATA_W-1:0];
      end
    end else begin : g_wide
      always_ff @(posedge clk) begin
        if (rd_en) rd_data <= DATA_W'(word);
      end
    end
  endgenerate

endmodule

// File: rtl/copy_seq.sv
`timescale 1ns/1ps
module copy_seq #(
  parameter int IMG_LEN = 128,
  localparam int IDX_W  = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1,
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_LEN - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_ready,
  input  logic             wr_ready,
  output logic             rom_rd,
  output logic [IDX_W-1:0] idx,
  output logic             wr_valid,
  output logic             cpu_hold,
  output logic             done
);
  import boot_copier_pkg::*;

  cp_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CP_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        CP_IDLE:  if (src_ready) state <= CP_READ;
        CP_READ:  state <= CP_WRITE;
        CP_WRITE: if (wr_ready) begin
                    if (idx == LAST_IDX) begin
                      state <= CP_DONE;
                    end else begin
                      idx   <= idx + 1'b1;
                      state <= CP_READ;
                    end
                  end
        CP_DONE:  state <= CP_DONE;
        default:  state <= CP_IDLE;
      endcase
    end
  end

  always_comb begin
    rom_rd   = (state == CP_READ);
    wr_valid = (state == CP_WRITE);
    cpu_hold = (state != CP_DONE);
    done     = (state == CP_DONE);
  end

  // R3: a sampled ready while idle launches a table read next cycle
  a_r3_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CP_IDLE && src_ready) |=> rom_rd);

  // R2: idle without ready keeps the processor held and the port quiet
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CP_IDLE && !src_ready) |=> (cpu_hold && !wr_valid));

endmodule

// File: rtl/boot_copier.sv
`timescale 1ns/1ps
module boot_copier #(
  parameter int IMG_LEN = 128,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ready,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cpu_hold,
  output logic              done
);
  localparam int IDX_W = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_LEN - 1);

  logic             rom_rd;
  logic [IDX_W-1:0] idx;

  copy_seq #(.IMG_LEN(IMG_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_ready (src_ready),
    .wr_ready  (wr_ready),
    .rom_rd    (rom_rd),
    .idx       (idx),
    .wr_valid  (wr_valid),
    .cpu_hold  (cpu_hold),
    .done      (done)
  );

  boot_rom #(.IMG_LEN(IMG_LEN), .DATA_W(DATA_W)) u_rom (
    .clk     (clk),
    .rd_en   (rom_rd),
    .rd_idx  (idx),
    .rd_data (wr_data)
  );

  always_comb wr_addr = ADDR_W'(idx);

  // R7: a stalled beat is held unchanged
  a_r7_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R6: an accepted beat is followed by a read cycle without a beat
  a_r6_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid);

  // R8: release only right after the final address is accepted
  a_r8_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> ($past(wr_valid && wr_ready && (wr_addr == LAST_ADDR)) && done));

  // R9: done is sticky and the processor stays released
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !cpu_hold));

  // R9: no write beat once done
  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

endmodule

// File: tb/boot_copier_tb.sv
`timescale 1ns/1ps
module boot_copier_tb;
  localparam int IMG_LEN = 128;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int NVEC    = 4;

  // Scenario vectors: idle wait, back-pressure on, drop ready after start
  localparam int IDLE_WAIT [NVEC] = '{0, 20, 5, 40};
  localparam bit STALL_ON  [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit DROP_RDY  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              src_ready;
  logic              wr_ready;
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              cpu_hold;
  logic              done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boot_copier #(.IMG_LEN(IMG_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_hold(cpu_hold), .done(done)
  );

  function automatic logic [DATA_W-1:0] exp_byte(input int i);
    int v;
    v = (i * 37 + 5) ^ (i / 8);
    return DATA_W'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Back-pressure driver
  logic [7:0] lfsr = 8'hA5;
  bit stall_en = 1'b0;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready = stall_en ? (lfsr[0] & lfsr[2]) : 1'b1;
  end

  // Port monitor
  int exp_next = 0;
  int wcount = 0;
  bit done_seen = 1'b0;
  bit prev_stall = 1'b0;
  bit prev_acc = 1'b0;
  logic [ADDR_W-1:0] prev_addr;
  logic [DATA_W-1:0] prev_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_next = 0; wcount = 0; done_seen = 1'b0;
      prev_stall = 1'b0; prev_acc = 1'b0;
    end else begin
      if (prev_acc) chk(!wr_valid, "R6", "beat right after accept", wr_valid, 0);
      if (prev_stall) begin
        chk(wr_valid, "R7", "valid dropped in stall", wr_valid, 1);
        chk(wr_addr == prev_addr, "R7", "addr moved in stall", wr_addr, prev_addr);
        chk(wr_data == prev_data, "R7", "data moved in stall", wr_data, prev_data);
      end
      chk(done == !cpu_hold, "R8", "done vs release", done, !cpu_hold);
      if (done && !done_seen) begin
        chk(wcount == IMG_LEN, "R8", "beats before release", wcount, IMG_LEN);
        done_seen = 1'b1;
      end else if (done_seen) begin
        chk(done && !cpu_hold, "R9", "done not sticky", done, 1);
        chk(!wr_valid, "R9", "beat after done", wr_valid, 0);
      end
      if (wr_valid && wr_ready) begin
        chk(wr_addr == ADDR_W'(exp_next), "R4", "write address", wr_addr, exp_next);
        chk(wr_data == exp_byte(exp_next), "R5", "write data", wr_data, exp_byte(exp_next));
        exp_next++;
        wcount++;
      end
      prev_acc   = wr_valid && wr_ready;
      prev_stall = wr_valid && !wr_ready;
      prev_addr  = wr_addr;
      prev_data  = wr_data;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; src_ready = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    bit ok;
    rst_n = 1'b0; src_ready = 1'b0; wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    chk(cpu_hold && !done && !wr_valid, "R1", "in reset", {cpu_hold, done, wr_valid}, 3'b100);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_hold && !done && !wr_valid, "R1", "after reset", {cpu_hold, done, wr_valid}, 3'b100);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      stall_en = STALL_ON[v];
      for (int k = 0; k < IDLE_WAIT[v]; k++) begin
        @(negedge clk);
        chk(cpu_hold && !wr_valid, "R2", "idle without ready", {cpu_hold, wr_valid}, 2'b10);
      end
      @(posedge clk); #1 src_ready = 1'b1;
      if (DROP_RDY[v]) begin
        @(posedge clk); #1 src_ready = 1'b0;   // R3: must be ignored now
      end
      wait_done(ok);
      chk(ok, "R3", "copy finished", ok, 1);
      chk(wcount == IMG_LEN, "R4", "beat count", wcount, IMG_LEN);
      repeat (10) @(negedge clk);
      chk(done && !cpu_hold, "R9", "still done later", done, 1);
      src_ready = 1'b0;
      stall_en = 1'b0;
    end

    // R10: reset in the middle of a copy, then restart from zero
    do_reset();
    stall_en = 1'b1;
    @(posedge clk); #1 src_ready = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (exp_next >= 40) break;
    end
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk(cpu_hold && !done && !wr_valid, "R10", "hold on mid-copy reset",
        {cpu_hold, done, wr_valid}, 3'b100);
    @(posedge clk); #1 rst_n = 1'b1;
    wait_done(ok);
    chk(ok, "R10", "restarted copy finished", ok, 1);
    chk(wcount == IMG_LEN, "R10", "restart beat count", wcount, IMG_LEN);
    stall_en = 1'b0;
    src_ready = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule